// File: doc/BRIEF.md
# Capture, Compare and PWM Timer Unit

This block is a timer peripheral built around one 16-bit data register, which software reaches one byte at a time. A 4-bit mode field picks one of three jobs for that register. In capture mode it latches a free-running 16-bit timer when an input pin changes. In compare mode it watches the same timer and acts when the timer equals the register. In PWM mode it drives a pulse-width-modulated output, using an 8-bit timer extended by two fraction bits.

Software writes bytes through a valid/ready port and reads them through a combinational read port. A write is taken on any clock edge where both `wr_valid_i` and `wr_ready_o` are high. `wr_ready_o` drops for one cycle when a capture loads the data register, so the capture always wins. The master must hold its address and data until the write is accepted. There is no back-pressure on the read side.

The block's outputs are the pin drive, a sticky interrupt flag and a one-cycle special-event pulse. That pulse resets the 16-bit timer and, when the converter is enabled, requests an A/D conversion.

Top module: `ccp_unit`

## Requirements
- R1: Address 0 selects the data low byte, address 1 the data high byte, and address 2 the control byte. The control byte holds the duty fraction in bits 5:4 and the mode in bits 3:0, and reads bits 7:6 as 0. Address 3 reads 0.
- R2: `wr_ready_o` is low in exactly the cycle a capture loads the data register. A write offered in that cycle is held off and is taken on the next edge.
- R3: Modes 0000 to 0011 disable the unit. They clear the capture prescaler, the compare output latch and the PWM state, drive the pin low, and never set the flag. A compare mode entered after this starts with the pin low.
- R4: Mode 0101 captures on each rising pin edge and mode 0100 on each falling edge. The value stored is the timer value at the third rising clock edge after the pin changes (two synchronizer stages), and the flag is set on that same edge.
- R5: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th. The earlier edges leave the data register and the flag untouched.
- R6: Any write that changes the mode clears the prescaler count.
- R7: Mode 1000 drives the pin high and mode 1001 drives it low one clock after the timer starts to equal the data register. Both set the flag. A match that is held acts only once.
- R8: Mode 1010 sets only the flag on a match and leaves the pin unchanged.
- R9: Mode 1011 sets the flag on a match and leaves the pin unchanged. It raises `special_evt_o` and `tmr16_reset_o` for exactly one cycle. `adc_start_o` pulses with them only when `adc_enable_i` is high.
- R10: Modes 11xx select PWM with a 10-bit duty of {low byte, control bits 5:4}. On a period pulse the duty is copied to a shadow register and the pin goes high, unless the duty is 0. The pin goes low when {`tmr8_i`, `tmr8_frac_i`} equals the shadow. A duty written mid-period waits for the next period pulse.
- R11: The flag stays set until `int_clr_i`. If a new event and a clear arrive in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr16_i | input | 16 | Free-running 16-bit timer value |
| tmr8_i | input | 8 | 8-bit PWM timer value |
| tmr8_frac_i | input | 2 | Two extension bits below the 8-bit timer |
| tmr8_period_hit_i | input | 1 | One-cycle pulse when the 8-bit timer rolls over on its period |
| cap_pin_i | input | 1 | Asynchronous capture input pin |
| wr_valid_i | input | 1 | Write request |
| wr_ready_o | output | 1 | Write can be taken this cycle |
| wr_addr_i | input | 2 | Write byte address |
| wr_data_i | input | 8 | Write byte |
| rd_addr_i | input | 2 | Read byte address |
| rd_data_o | output | 8 | Read byte (combinational) |
| int_clr_i | input | 1 | Clear the interrupt flag |
| adc_enable_i | input | 1 | A/D converter is enabled |
| pin_o | output | 1 | Output pin drive |
| int_flag_o | output | 1 | Sticky interrupt flag |
| special_evt_o | output | 1 | Special-event pulse |
| tmr16_reset_o | output | 1 | Reset request to the 16-bit timer |
| adc_start_o | output | 1 | A/D conversion request |

## Verification
Several properties are checked on every cycle:
- the flag is sticky;
- the special event only follows the trigger mode;
- the pin stays put in the flag-only and trigger compare modes;
- the PWM shadow changes only after a period pulse;
- a compare mode entered from disable starts low;
- a stalled write always coincides with a flag-setting capture.

Some behaviours can only be shown by the bench's directed scenarios:
- the exact captured timer value and its sync latency;
- the 4th and 16th edge counting and its clearing on a mode change;
- the set/clear/pulse actions of each compare mode;
- the PWM high and low times against a written duty.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int TMR_W   = 16;
  localparam int BYTE_W  = 8;
  localparam int FRAC_W  = 2;
  localparam int DUTY_W  = BYTE_W + FRAC_W;
  localparam int MODE_W  = 4;
  localparam int PRE_MAX = 16;
  localparam int PRE_W   = $clog2(PRE_MAX);
  localparam int NBYTES  = TMR_W / BYTE_W;

  localparam logic [1:0] ADDR_LO   = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  localparam logic [MODE_W-1:0] M_CAP_FALL = 4'b0100;
  localparam logic [MODE_W-1:0] M_CMP_SET  = 4'b1000;
  localparam logic [MODE_W-1:0] M_CMP_CLR  = 4'b1001;
  localparam logic [MODE_W-1:0] M_CMP_TRIG = 4'b1011;

  typedef enum logic [1:0] {
    FN_OFF = 2'b00,
    FN_CAP = 2'b01,
    FN_CMP = 2'b10,
    FN_PWM = 2'b11
  } ccp_fn_e;

  function automatic ccp_fn_e fn_of(input logic [MODE_W-1:0] m);
    return ccp_fn_e'(m[3:2]);
  endfunction
endpackage

// File: rtl/ccp_edge_capture.sv
module ccp_edge_capture
  import ccp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              clear_i,
  output logic              fire_o
);
  logic [SYNC_STAGES:0] sh_q;
  logic [PRE_W-1:0]     cnt_q;
  logic [PRE_W-1:0]     last_cnt;
  logic                 active, edge_seen, pin_now, pin_prev;

  assign pin_now  = sh_q[SYNC_STAGES-1];
  assign pin_prev = sh_q[SYNC_STAGES];
  assign active   = (fn_of(mode_i) == FN_CAP);

  always_comb begin
    if (mode_i == M_CAP_FALL) edge_seen = pin_prev & ~pin_now;
    else                      edge_seen = pin_now & ~pin_prev;
    case (mode_i[1:0])
      2'b10:   last_cnt = PRE_W'(3);
      2'b11:   last_cnt = PRE_W'(PRE_MAX - 1);
      default: last_cnt = '0;
    endcase
  end

  assign fire_o = active && edge_seen && (cnt_q == last_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SYNC_STAGES-1:0], pin_i};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !active || clear_i) cnt_q <= '0;
    else if (edge_seen)               cnt_q <= (cnt_q == last_cnt) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/ccp_compare.sv
module ccp_compare
  import ccp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TMR_W-1:0]  timer_i,
  input  logic [TMR_W-1:0]  ref_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              evt_o,
  output logic              latch_o,
  output logic              special_o
);
  logic active, match, match_q;

  assign active = (fn_of(mode_i) == FN_CMP);
  assign match  = (timer_i == ref_i);
  assign evt_o  = active && match && !match_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q   <= 1'b0;
      latch_o   <= 1'b0;
      special_o <= 1'b0;
    end else begin
      match_q   <= active && match;
      special_o <= evt_o && (mode_i == M_CMP_TRIG);
      if (fn_of(mode_i) == FN_OFF)               latch_o <= 1'b0;
      else if (evt_o && mode_i == M_CMP_SET)     latch_o <= 1'b1;
      else if (evt_o && mode_i == M_CMP_CLR)     latch_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ccp_pwm.sv
module ccp_pwm
  import ccp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic [DUTY_W-1:0] tmr_ext_i,
  input  logic              period_hit_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pin_o,
  output logic [DUTY_W-1:0] shadow_o
);
  always_ff @(posedge clk) begin
    if (!rst_n || !active_i) begin
      pin_o    <= 1'b0;
      shadow_o <= '0;
    end else if (period_hit_i) begin
      shadow_o <= duty_i;
      pin_o    <= (duty_i != '0);
    end else if (tmr_ext_i == shadow_o) begin
      pin_o    <= 1'b0;
    end
  end
endmodule

// File: rtl/ccp_unit.sv
module ccp_unit
  import ccp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TMR_W-1:0]  tmr16_i,
  input  logic [BYTE_W-1:0] tmr8_i,
  input  logic [FRAC_W-1:0] tmr8_frac_i,
  input  logic              tmr8_period_hit_i,
  input  logic              cap_pin_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [1:0]        wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic              int_clr_i,
  input  logic              adc_enable_i,
  output logic              pin_o,
  output logic              int_flag_o,
  output logic              special_evt_o,
  output logic              tmr16_reset_o,
  output logic              adc_start_o
);
  logic [TMR_W-1:0]  data_q;
  logic [MODE_W-1:0] mode_q;
  logic [FRAC_W-1:0] frac_q;
  logic              wr_fire, mode_chg, cap_fire, cmp_evt, cmp_latch, pwm_pin;
  logic [DUTY_W-1:0] pwm_shadow;

  assign wr_ready_o = !cap_fire;
  assign wr_fire    = wr_valid_i && wr_ready_o;
  assign mode_chg   = wr_fire && (wr_addr_i == ADDR_CTRL) &&
                      (wr_data_i[MODE_W-1:0] != mode_q);

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)
        data_q[b*BYTE_W +: BYTE_W] <= '0;
      else if (cap_fire)
        data_q[b*BYTE_W +: BYTE_W] <= tmr16_i[b*BYTE_W +: BYTE_W];
      else if (wr_fire && wr_addr_i == 2'(b))
        data_q[b*BYTE_W +: BYTE_W] <= wr_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      frac_q <= '0;
    end else if (wr_fire && wr_addr_i == ADDR_CTRL) begin
      mode_q <= wr_data_i[MODE_W-1:0];
      frac_q <= wr_data_i[MODE_W +: FRAC_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   int_flag_o <= 1'b0;
    else if (cap_fire || cmp_evt) int_flag_o <= 1'b1;
    else if (int_clr_i)           int_flag_o <= 1'b0;
  end

  ccp_edge_capture #(.SYNC_STAGES(2)) u_cap (
    .clk(clk), .rst_n(rst_n), .pin_i(cap_pin_i), .mode_i(mode_q),
    .clear_i(mode_chg), .fire_o(cap_fire)
  );

  ccp_compare u_cmp (
    .clk(clk), .rst_n(rst_n), .timer_i(tmr16_i), .ref_i(data_q),
    .mode_i(mode_q), .evt_o(cmp_evt), .latch_o(cmp_latch),
    .special_o(special_evt_o)
  );

  ccp_pwm u_pwm (
    .clk(clk), .rst_n(rst_n), .active_i(fn_of(mode_q) == FN_PWM),
    .tmr_ext_i({tmr8_i, tmr8_frac_i}), .period_hit_i(tmr8_period_hit_i),
    .duty_i({data_q[BYTE_W-1:0], frac_q}), .pin_o(pwm_pin),
    .shadow_o(pwm_shadow)
  );

  assign tmr16_reset_o = special_evt_o;
  assign adc_start_o   = special_evt_o && adc_enable_i;

  always_comb begin
    case (fn_of(mode_q))
      FN_CMP:  pin_o = cmp_latch;
      FN_PWM:  pin_o = pwm_pin;
      default: pin_o = 1'b0;
    endcase
    case (rd_addr_i)
      ADDR_LO:   rd_data_o = data_q[BYTE_W-1:0];
      ADDR_HI:   rd_data_o = data_q[TMR_W-1:BYTE_W];
      ADDR_CTRL: rd_data_o = {2'b00, frac_q, mode_q};
      default:   rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/ccp_unit_chk.sv
module ccp_unit_chk
  import ccp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] mode,
  input logic              int_flag_o,
  input logic              int_clr_i,
  input logic              pin_o,
  input logic              special_evt_o,
  input logic              tmr8_period_hit_i,
  input logic [DUTY_W-1:0] pwm_shadow,
  input logic              wr_ready_o
);
  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (int_flag_o && !int_clr_i) |=> int_flag_o);

  a_r9_special_from_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    special_evt_o |-> ($past(mode) == M_CMP_TRIG));

  a_r8_pin_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[3:1] == 3'b101 && $past(mode[3:1]) == 3'b101) |-> $stable(pin_o));

  a_r10_shadow_on_period: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[3:2] == 2'b11 && $past(mode[3:2]) == 2'b11 && !$past(tmr8_period_hit_i))
      |-> $stable(pwm_shadow));

  a_r3_off_clears_latch: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode[3:2]) == 2'b00 && mode[3:2] == 2'b10) |-> !pin_o);

  a_r2_stall_is_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready_o |=> int_flag_o);
endmodule

bind ccp_unit ccp_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode_q), .int_flag_o(int_flag_o),
  .int_clr_i(int_clr_i), .pin_o(pin_o), .special_evt_o(special_evt_o),
  .tmr8_period_hit_i(tmr8_period_hit_i), .pwm_shadow(pwm_shadow),
  .wr_ready_o(wr_ready_o)
);

// File: tb/ccp_unit_tb.sv
module ccp_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tmr16 = '0;
  logic [7:0]  tmr8 = '0;
  logic [1:0]  tmr8_frac = '0;
  logic        period_hit = 1'b0;
  logic        cap_pin = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [1:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        int_clr = 1'b0;
  logic        adc_en = 1'b0;
  logic        pin, flag, special, t16_rst, adc_start;
  int          n_checks = 0;
  int          n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccp_unit dut_i (
    .clk(clk), .rst_n(rst_n), .tmr16_i(tmr16), .tmr8_i(tmr8),
    .tmr8_frac_i(tmr8_frac), .tmr8_period_hit_i(period_hit),
    .cap_pin_i(cap_pin), .wr_valid_i(wr_valid), .wr_ready_o(wr_ready),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .int_clr_i(int_clr), .adc_enable_i(adc_en),
    .pin_o(pin), .int_flag_o(flag), .special_evt_o(special),
    .tmr16_reset_o(t16_rst), .adc_start_o(adc_start)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic clear_flag();
    @(negedge clk); int_clr = 1'b1;
    @(negedge clk); int_clr = 1'b0;
  endtask

  task automatic set_tmr(input logic [15:0] v);
    @(negedge clk); tmr16 = v;
  endtask

  task automatic pulse_pin();
    @(negedge clk); cap_pin = 1'b1;
    repeat (4) @(negedge clk);
    cap_pin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd0, d); chk("R1 reset low byte", 16'(d), 16'h00);
    rd(2'd1, d); chk("R1 reset high byte", 16'(d), 16'h00);
    rd(2'd2, d); chk("R1 reset control", 16'(d), 16'h00);
    chk("R3 reset pin", 16'(pin), 16'h0);
    chk("R11 reset flag", 16'(flag), 16'h0);
    chk("R2 reset ready", 16'(wr_ready), 16'h1);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    write_reg(2'd0, 8'hA5);
    write_reg(2'd1, 8'h3C);
    write_reg(2'd2, 8'hFF);
    rd(2'd0, d); chk("R1 low byte", 16'(d), 16'hA5);
    rd(2'd1, d); chk("R1 high byte", 16'(d), 16'h3C);
    rd(2'd2, d); chk("R1 control top bits zero", 16'(d), 16'h3F);
    rd(2'd3, d); chk("R1 unused address", 16'(d), 16'h00);
    write_reg(2'd2, 8'h00);
  endtask

  task automatic t_capture_rise();
    logic [7:0] d;
    tmr16 = 16'h1234;
    write_reg(2'd2, 8'h05);
    clear_flag();
    @(negedge clk); cap_pin = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 ready low during capture", 16'(wr_ready), 16'h0);
    wr_valid = 1'b1; wr_addr = 2'd0; wr_data = 8'hAA;
    @(negedge clk);
    rd(2'd0, d); chk("R2 write held off, R4 low", 16'(d), 16'h34);
    rd(2'd1, d); chk("R4 rising capture high", 16'(d), 16'h12);
    chk("R4 flag on capture", 16'(flag), 16'h1);
    @(negedge clk); wr_valid = 1'b0;
    rd(2'd0, d); chk("R2 stalled write taken", 16'(d), 16'hAA);
  endtask

  task automatic t_capture_fall();
    logic [7:0] d;
    tmr16 = 16'hBEEF;
    write_reg(2'd2, 8'h04);
    clear_flag();
    repeat (4) @(negedge clk);
    chk("R4 no capture without falling edge", 16'(flag), 16'h0);
    cap_pin = 1'b0;
    repeat (3) @(negedge clk);
    rd(2'd0, d); chk("R4 falling capture low", 16'(d), 16'hEF);
    rd(2'd1, d); chk("R4 falling capture high", 16'(d), 16'hBE);
  endtask

  task automatic t_prescale(input logic [7:0] ctrl, input int n);
    logic [7:0] lo, hi;
    write_reg(2'd2, ctrl);
    clear_flag();
    tmr16 = 16'h0F0F;
    for (int i = 1; i < n; i++) begin
      tmr16 = 16'h1000 + 16'(i);
      pulse_pin();
    end
    rd(2'd0, lo); rd(2'd1, hi);
    chk("R5 early edges no capture", {hi, lo}, (n == 4) ? 16'hFF00 : 16'h0000);
    chk("R5 early edges no flag", 16'(flag), 16'h0);
    tmr16 = (n == 4) ? 16'h2222 : 16'h3333;
    pulse_pin();
    rd(2'd0, lo); rd(2'd1, hi);
    chk("R5 prescaled capture", {hi, lo}, (n == 4) ? 16'h2222 : 16'h3333);
    chk("R5 prescaled flag", 16'(flag), 16'h1);
  endtask

  task automatic t_prescale_clear();
    logic [7:0] lo, hi;
    write_reg(2'd2, 8'h06);
    clear_flag();
    tmr16 = 16'h4444;
    pulse_pin(); pulse_pin();
    write_reg(2'd2, 8'h07);
    write_reg(2'd2, 8'h06);
    tmr16 = 16'h5555;
    pulse_pin(); pulse_pin(); pulse_pin();
    chk("R6 count restarted after mode change", 16'(flag), 16'h0);
    tmr16 = 16'h6666;
    pulse_pin();
    rd(2'd0, lo); rd(2'd1, hi);
    chk("R6 capture on fourth edge after clear", {hi, lo}, 16'h6666);
  endtask

  task automatic t_compare();
    write_reg(2'd2, 8'h00);
    tmr16 = 16'h0000;
    write_reg(2'd0, 8'h40);
    write_reg(2'd1, 8'h00);
    write_reg(2'd2, 8'h08);
    clear_flag();
    chk("R3 compare starts low", 16'(pin), 16'h0);
    set_tmr(16'h0040);
    @(negedge clk);
    chk("R7 set on match", 16'(pin), 16'h1);
    chk("R7 flag on match", 16'(flag), 16'h1);
    clear_flag();
    repeat (2) @(negedge clk);
    chk("R7 held match acts once", 16'(flag), 16'h0);
    write_reg(2'd2, 8'h09);
    set_tmr(16'h0041); set_tmr(16'h0040);
    @(negedge clk);
    chk("R7 clear on match", 16'(pin), 16'h0);
    write_reg(2'd2, 8'h08);
    set_tmr(16'h0041); set_tmr(16'h0040);
    @(negedge clk);
    write_reg(2'd2, 8'h0A);
    clear_flag();
    set_tmr(16'h0041); set_tmr(16'h0040);
    @(negedge clk);
    chk("R8 flag only mode pin kept", 16'(pin), 16'h1);
    chk("R8 flag only mode flag", 16'(flag), 16'h1);
    chk("R8 no special event", 16'(special), 16'h0);
    write_reg(2'd2, 8'h0B);
    adc_en = 1'b1;
    clear_flag();
    set_tmr(16'h0041); set_tmr(16'h0040);
    @(negedge clk);
    chk("R9 special pulse", 16'(special), 16'h1);
    chk("R9 timer reset pulse", 16'(t16_rst), 16'h1);
    chk("R9 adc start enabled", 16'(adc_start), 16'h1);
    chk("R9 pin kept", 16'(pin), 16'h1);
    chk("R9 flag", 16'(flag), 16'h1);
    @(negedge clk);
    chk("R9 pulse one cycle", 16'(special), 16'h0);
    set_tmr(16'h0041);
    adc_en = 1'b0;
    set_tmr(16'h0040);
    @(negedge clk);
    chk("R9 special with adc off", 16'(special), 16'h1);
    chk("R9 adc start gated", 16'(adc_start), 16'h0);
  endtask

  task automatic t_flag();
    write_reg(2'd2, 8'h0A);
    set_tmr(16'h0041);
    clear_flag();
    @(negedge clk); tmr16 = 16'h0040; int_clr = 1'b1;
    @(negedge clk); int_clr = 1'b0;
    chk("R11 set wins over clear", 16'(flag), 16'h1);
    clear_flag();
    chk("R11 clear", 16'(flag), 16'h0);
  endtask

  task automatic t_disable();
    write_reg(2'd2, 8'h08);
    set_tmr(16'h0041); set_tmr(16'h0040);
    @(negedge clk);
    write_reg(2'd2, 8'h00);
    chk("R3 disabled pin low", 16'(pin), 16'h0);
    clear_flag();
    set_tmr(16'h0041); set_tmr(16'h0040);
    @(negedge clk);
    chk("R3 disabled no flag", 16'(flag), 16'h0);
    set_tmr(16'h0000);
    write_reg(2'd2, 8'h08);
    chk("R3 latch cleared by disable", 16'(pin), 16'h0);
  endtask

  task automatic hit();
    @(negedge clk); period_hit = 1'b1;
    @(negedge clk); period_hit = 1'b0;
  endtask

  task automatic set_ext(input logic [7:0] t, input logic [1:0] f);
    @(negedge clk); tmr8 = t; tmr8_frac = f;
  endtask

  task automatic t_pwm();
    write_reg(2'd2, 8'h00);
    write_reg(2'd0, 8'h05);
    set_ext(8'd0, 2'd0);
    write_reg(2'd2, 8'h2C);
    chk("R10 low before period", 16'(pin), 16'h0);
    hit();
    chk("R10 high at period", 16'(pin), 16'h1);
    set_ext(8'd5, 2'd1);
    write_reg(2'd0, 8'h02);
    set_ext(8'd2, 2'd2);
    @(negedge clk);
    chk("R10 new duty waits for period", 16'(pin), 16'h1);
    set_ext(8'd5, 2'd2);
    @(negedge clk);
    chk("R10 low at duty 22", 16'(pin), 16'h0);
    set_ext(8'd0, 2'd0);
    hit();
    chk("R10 high again", 16'(pin), 16'h1);
    set_ext(8'd2, 2'd2);
    @(negedge clk);
    chk("R10 low at duty 10", 16'(pin), 16'h0);
    write_reg(2'd0, 8'h00);
    write_reg(2'd2, 8'h0C);
    set_ext(8'd0, 2'd0);
    hit();
    chk("R10 zero duty stays low", 16'(pin), 16'h0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_capture_rise();
    t_capture_fall();
    write_reg(2'd0, 8'h00);
    write_reg(2'd1, 8'hFF);
    t_prescale(8'h06, 4);
    write_reg(2'd0, 8'h00);
    write_reg(2'd1, 8'h00);
    t_prescale(8'h07, 16);
    t_prescale_clear();
    t_compare();
    t_flag();
    t_disable();
    t_pwm();
    summary();
    $finish;
  end
endmodule